// File: doc/BRIEF.md
# Transfer Information Length Controller

This block runs the transfer-information command of a bus-attached storage controller. When the command starts in DMA mode it works out how many bytes to move. That count is the smaller of the programmed 16-bit transfer count, where zero stands for 65536, and the size of the signed remaining-data length. When command bytes are still pending, the cap is 32 bytes instead of the remaining length. The block then hands out one byte per valid/ready handshake on its DMA port. It pauses whenever the attached target has no buffered data, and it finishes by updating its status, interrupt, FIFO-fill and count registers and raising the interrupt line.

The sign of the remaining length gives the direction. A positive value means data flows from the device to the host. A negative value means data flows from the host to the device. Every accepted byte moves the value one step toward zero. The target side is modelled by two pulses: a buffer-length load, and an end-of-command report that carries a status byte. The block also holds a 32-byte FIFO for programmed-I/O data. Its read and write pointers follow the remaining length, and both pointers go back to zero once that length runs out.

Top module: `xfer_len_ctrl`

## Requirements
- R1: After reset, status, interrupt code, count, FIFO fill, remaining length, sense byte and the interrupt line are all zero, and no DMA request is shown.
- R2: A DMA start moves exactly min(C, |L|) bytes, where C is the count (a count of 0 means 65536) and L is the signed remaining length. With command bytes pending it moves min(C, 32) bytes, ignores target buffering, and leaves L unchanged.
- R3: Status bit 4 (count-done) is cleared by a DMA start and by a count write.
- R4: Each accepted DMA byte outside command mode moves the remaining length one step toward zero. The request is only shown while bytes of the effective length remain.
- R5: Completion sets status bits 7 and 4, sets the interrupt code to 0x10, clears the count and FIFO fill, and raises the interrupt line on the next clock.
- R6: When the target buffer is empty before the effective length is used up, requests stop. They resume when a new target buffer length is loaded.
- R7: When the effective length runs out, completion follows on the next clock if the target buffer still holds bytes or the remaining length is positive. Otherwise completion waits for the next target buffer load.
- R8: An end-of-command report clears the remaining length, latches its status byte as the sense byte, sets status phase bits [2:0] to 3, and runs completion, which gives status 0x93.
- R9: A programmed-I/O read while the remaining length is positive returns the oldest FIFO byte, decrements the length and raises the interrupt. When the length reaches zero, both FIFO pointers and the fill count reset.
- R10: A programmed-I/O read while the remaining length is zero or negative leaves the length, the read data and the interrupt line unchanged.
- R11: An interrupt acknowledge lowers the interrupt line and clears status bit 7, but leaves bit 4 as it was.
- R12: A start with the DMA flag clear moves no data and changes neither the status nor the remaining length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Transfer-information start pulse |
| cmdDma | input | 1 | Start uses DMA when high |
| cmdPending | input | 1 | Command bytes pending (32-byte cap) |
| countWr | input | 1 | Load the transfer count |
| countIn | input | 16 | Transfer count value |
| remLoad | input | 1 | Load the signed remaining length |
| remLoadVal | input | 24 | Signed remaining length value |
| tgtLoad | input | 1 | Target supplies a buffer |
| tgtLen | input | 17 | Bytes in the supplied target buffer |
| tgtDone | input | 1 | Target reports end of command |
| tgtStatus | input | 8 | Status byte reported with end of command |
| dmaReq | output | 1 | Byte available on the DMA handshake |
| dmaAck | input | 1 | DMA side accepts the byte |
| pioRd | input | 1 | Programmed-I/O FIFO read |
| pioWr | input | 1 | Programmed-I/O FIFO write |
| pioWrData | input | 8 | FIFO write byte |
| pioData | output | 8 | Last byte read from the FIFO |
| intrAck | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt line |
| statusReg | output | 8 | Status register |
| intrReg | output | 8 | Interrupt code register |
| countReg | output | 16 | Current transfer count |
| fifoFlags | output | 6 | FIFO fill count |
| remLen | output | 24 | Signed remaining length |
| senseByte | output | 8 | Latched target status byte |

## Verification
The bench targets the length arithmetic at its edges: a zero count that must mean 65536, a negative length whose magnitude sets the limit, and the 32-byte command cap. A design that mishandled any of these would move a visibly wrong number of bytes. It drains the target buffer early and at the exact moment the count ends, so that a design which finished too soon or waited forever would show a wrong interrupt level. It also empties the FIFO through a read and then writes a new byte, which exposes pointers that fail to reset. Finally, it reads with a zero or negative length, which shows whether the design wrongly updates data or the interrupt.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef struct packed {
    logic loadDma;   // latch effective length, enter run
    logic byteGo;    // one byte accepted on the DMA handshake
    logic complete;  // run the completion update
    logic tgtEnd;    // target reported end of command
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_WAIT = 2'd2
  } xferState_t;

  localparam logic [7:0] ST_INT_BIT  = 8'h80;
  localparam logic [7:0] ST_CNT_BIT  = 8'h10;
  localparam logic [7:0] INT_SERVICE = 8'h10;
  localparam logic [7:0] ST_PHASE_ST = 8'h03;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        cmdDma,
  input  logic        cmdPending,
  input  logic        tgtLoad,
  input  logic        tgtDone,
  input  logic        dmaAck,
  input  logic        dpLeftZero,
  input  logic        dpTgtEmpty,
  input  logic        dpRemPos,
  output logic        dmaReq,
  output logic        cmdModeQ,
  output ctlStrobes_t stb
);

  xferState_t stateQ, stateNext;
  logic running, exhaust, finishNow, deferEnter, waitRelease;

  always_comb begin
    running     = (stateQ == S_RUN);
    dmaReq      = running && !dpLeftZero && (cmdModeQ || !dpTgtEmpty);
    exhaust     = running && dpLeftZero;
    // a buffer loaded in the same cycle counts as fresh target data
    finishNow   = exhaust && (cmdModeQ || !dpTgtEmpty || dpRemPos || tgtLoad);
    deferEnter  = exhaust && !finishNow;
    waitRelease = (stateQ == S_WAIT) && tgtLoad;

    stb.tgtEnd   = tgtDone;
    stb.loadDma  = (stateQ == S_IDLE) && cmdStart && cmdDma && !tgtDone;
    stb.byteGo   = dmaReq && dmaAck && !tgtDone;
    stb.complete = tgtDone || finishNow || waitRelease;

    stateNext = stateQ;
    if (tgtDone)                         stateNext = S_IDLE;
    else if (stb.loadDma)                stateNext = S_RUN;
    else if (finishNow || waitRelease)   stateNext = S_IDLE;
    else if (deferEnter)                 stateNext = S_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      cmdModeQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stb.loadDma) cmdModeQ <= cmdPending;
    end
  end

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int REM_W      = 24,
  parameter int FIFO_DEPTH = 32,
  localparam int LEN_W     = CNT_W + 1,
  localparam int PTR_W     = $clog2(FIFO_DEPTH),
  localparam int FILL_W    = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             stb,
  input  logic                    cmdModeQ,
  input  logic                    cmdPending,
  input  logic                    countWr,
  input  logic [CNT_W-1:0]        countIn,
  input  logic                    remLoad,
  input  logic signed [REM_W-1:0] remLoadVal,
  input  logic                    tgtLoad,
  input  logic [LEN_W-1:0]        tgtLen,
  input  logic [7:0]              tgtStatus,
  input  logic                    pioRd,
  input  logic                    pioWr,
  input  logic [7:0]              pioWrData,
  input  logic                    intrAck,
  output logic [7:0]              pioData,
  output logic                    irq,
  output logic [7:0]              statusReg,
  output logic [7:0]              intrReg,
  output logic [CNT_W-1:0]        countReg,
  output logic [FILL_W-1:0]       fifoFlags,
  output logic signed [REM_W-1:0] remLen,
  output logic [7:0]              senseByte,
  output logic                    dpLeftZero,
  output logic                    dpTgtEmpty,
  output logic                    dpRemPos
);

  localparam int CMP_W = (REM_W > LEN_W) ? REM_W : LEN_W;
  localparam logic signed [REM_W-1:0] REM_ONE = REM_W'(1);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);
  localparam logic [FILL_W-1:0] FILL_ONE = FILL_W'(1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(FIFO_DEPTH);
  localparam logic [CMP_W-1:0]  CMD_CAP  = CMP_W'(FIFO_DEPTH);

  logic signed [REM_W-1:0] remQ;
  logic [LEN_W-1:0]  dmaLeftQ, tgtLeftQ, countEff, effLen;
  logic [REM_W-1:0]  remMag;
  logic [CMP_W-1:0]  cntW, limW, effW;
  logic [CNT_W-1:0]  countQ;
  logic [7:0]        statusQ, statusNext, intrQ, senseQ, pioDataQ;
  logic [FILL_W-1:0] flagsQ;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [7:0]        fifoMem [FIFO_DEPTH];
  logic              irqQ;
  logic              remNeg, remZero, dmaMovesRem, remBlocked;
  logic              pioRdOk, pioWrOk, ptrClr;

  // effective length: count (zero -> full range) against remaining or cap
  always_comb begin
    countEff = (countQ == '0) ? (LEN_ONE << CNT_W) : {1'b0, countQ};
    remMag   = remQ[REM_W-1] ? $unsigned(-remQ) : $unsigned(remQ);
    cntW     = CMP_W'(countEff);
    limW     = cmdPending ? CMD_CAP : CMP_W'(remMag);
    effW     = (cntW < limW) ? cntW : limW;
    effLen   = LEN_W'(effW);
  end

  always_comb begin
    remNeg      = remQ[REM_W-1];
    remZero     = (remQ == '0);
    dpRemPos    = !remNeg && !remZero;
    dpLeftZero  = (dmaLeftQ == '0);
    dpTgtEmpty  = (tgtLeftQ == '0);
    dmaMovesRem = stb.byteGo && !cmdModeQ;
    remBlocked  = stb.tgtEnd || remLoad || dmaMovesRem;
    pioRdOk     = pioRd && dpRemPos && !remBlocked;
    pioWrOk     = pioWr && !pioRd && !remBlocked;
    ptrClr      = (pioRdOk && remQ == REM_ONE) ||
                  (pioRd && remZero && !remBlocked);
  end

  always_comb begin
    statusNext = statusQ;
    if (stb.loadDma || countWr) statusNext = statusNext & ~ST_CNT_BIT;
    if (intrAck)                statusNext = statusNext & 8'h1f;
    if (stb.tgtEnd)             statusNext = ST_PHASE_ST;
    if (stb.complete)           statusNext = statusNext | ST_INT_BIT | ST_CNT_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ     <= '0;
      dmaLeftQ <= '0;
      tgtLeftQ <= '0;
      countQ   <= '0;
      statusQ  <= '0;
      intrQ    <= '0;
      senseQ   <= '0;
      flagsQ   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      pioDataQ <= '0;
      irqQ     <= 1'b0;
    end else begin
      statusQ <= statusNext;

      // remaining length
      if (stb.tgtEnd)         remQ <= '0;
      else if (remLoad)       remQ <= remLoadVal;
      else if (dmaMovesRem) begin
        if (dpRemPos)         remQ <= remQ - REM_ONE;
        else if (remNeg)      remQ <= remQ + REM_ONE;
      end
      else if (pioRdOk)       remQ <= remQ - REM_ONE;
      else if (pioWrOk)       remQ <= remQ + REM_ONE;

      // DMA byte budget
      if (stb.tgtEnd)         dmaLeftQ <= '0;
      else if (stb.loadDma)   dmaLeftQ <= effLen;
      else if (stb.byteGo)    dmaLeftQ <= dmaLeftQ - LEN_ONE;

      // target buffer occupancy
      if (stb.tgtEnd)         tgtLeftQ <= '0;
      else if (tgtLoad)       tgtLeftQ <= tgtLen;
      else if (dmaMovesRem)   tgtLeftQ <= tgtLeftQ - LEN_ONE;

      if (stb.complete)       countQ <= '0;
      else if (countWr)       countQ <= countIn;

      if (stb.complete)       intrQ <= INT_SERVICE;
      if (stb.tgtEnd)         senseQ <= tgtStatus;

      if (stb.complete || pioRdOk) irqQ <= 1'b1;
      else if (intrAck)            irqQ <= 1'b0;

      // programmed-I/O FIFO pointers and fill
      if (ptrClr) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (pioWrOk) wrPtr <= wrPtr + PTR_ONE;
        if (pioRdOk) rdPtr <= rdPtr + PTR_ONE;
      end
      if (pioRdOk) pioDataQ <= fifoMem[rdPtr];

      if (stb.complete || ptrClr)           flagsQ <= '0;
      else if (pioWrOk && flagsQ < FILL_MAX) flagsQ <= flagsQ + FILL_ONE;
      else if (pioRdOk && flagsQ != '0)      flagsQ <= flagsQ - FILL_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (pioWrOk) fifoMem[wrPtr] <= pioWrData;
  end

  assign remLen    = remQ;
  assign statusReg = statusQ;
  assign intrReg   = intrQ;
  assign countReg  = countQ;
  assign fifoFlags = flagsQ;
  assign senseByte = senseQ;
  assign pioData   = pioDataQ;
  assign irq       = irqQ;

endmodule

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl
  import xfer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int REM_W      = 24,
  parameter int FIFO_DEPTH = 32,
  localparam int LEN_W     = CNT_W + 1,
  localparam int FILL_W    = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdStart,
  input  logic                    cmdDma,
  input  logic                    cmdPending,
  input  logic                    countWr,
  input  logic [CNT_W-1:0]        countIn,
  input  logic                    remLoad,
  input  logic signed [REM_W-1:0] remLoadVal,
  input  logic                    tgtLoad,
  input  logic [LEN_W-1:0]        tgtLen,
  input  logic                    tgtDone,
  input  logic [7:0]              tgtStatus,
  output logic                    dmaReq,
  input  logic                    dmaAck,
  input  logic                    pioRd,
  input  logic                    pioWr,
  input  logic [7:0]              pioWrData,
  output logic [7:0]              pioData,
  input  logic                    intrAck,
  output logic                    irq,
  output logic [7:0]              statusReg,
  output logic [7:0]              intrReg,
  output logic [CNT_W-1:0]        countReg,
  output logic [FILL_W-1:0]       fifoFlags,
  output logic signed [REM_W-1:0] remLen,
  output logic [7:0]              senseByte
);

  ctlStrobes_t stb;
  logic cmdModeQ, dpLeftZero, dpTgtEmpty, dpRemPos;

  xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdStart(cmdStart), .cmdDma(cmdDma), .cmdPending(cmdPending),
    .tgtLoad(tgtLoad), .tgtDone(tgtDone), .dmaAck(dmaAck),
    .dpLeftZero(dpLeftZero), .dpTgtEmpty(dpTgtEmpty), .dpRemPos(dpRemPos),
    .dmaReq(dmaReq), .cmdModeQ(cmdModeQ), .stb(stb)
  );

  xfer_datapath #(.CNT_W(CNT_W), .REM_W(REM_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdModeQ(cmdModeQ),
    .cmdPending(cmdPending), .countWr(countWr), .countIn(countIn),
    .remLoad(remLoad), .remLoadVal(remLoadVal),
    .tgtLoad(tgtLoad), .tgtLen(tgtLen), .tgtStatus(tgtStatus),
    .pioRd(pioRd), .pioWr(pioWr), .pioWrData(pioWrData), .intrAck(intrAck),
    .pioData(pioData), .irq(irq), .statusReg(statusReg), .intrReg(intrReg),
    .countReg(countReg), .fifoFlags(fifoFlags), .remLen(remLen),
    .senseByte(senseByte), .dpLeftZero(dpLeftZero), .dpTgtEmpty(dpTgtEmpty),
    .dpRemPos(dpRemPos)
  );

endmodule

// File: rtl/xfer_len_ctrl_chk.sv
module xfer_len_ctrl_chk
  import xfer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REM_W  = 24,
  parameter int FILL_W = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input ctlStrobes_t             stb,
  input logic                    dmaReq,
  input logic                    dmaAck,
  input logic                    tgtDone,
  input logic                    remLoad,
  input logic                    pioRd,
  input logic                    pioWr,
  input logic                    intrAck,
  input logic                    irq,
  input logic [7:0]              statusReg,
  input logic [7:0]              intrReg,
  input logic [CNT_W-1:0]        countReg,
  input logic [FILL_W-1:0]       fifoFlags,
  input logic signed [REM_W-1:0] remLen
);

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDma && !stb.complete |=> !statusReg[4]);

  p_byte_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && dmaAck && !tgtDone && !remLoad && !pioRd && !pioWr |=>
      (remLen == $past(remLen)) ||
      ($past(remLen) > 0 && remLen == $past(remLen) - 1) ||
      ($past(remLen) < 0 && remLen == $past(remLen) + 1));

  p_done_fields_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.complete |=> irq && intrReg == 8'h10 && countReg == '0 &&
                     fifoFlags == '0 && statusReg[7] && statusReg[4]);

  p_tgt_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    tgtDone |=> remLen == '0 && statusReg[2:0] == 3'd3);

  p_pio_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    pioRd && remLen > 0 && !(dmaReq && dmaAck) && !tgtDone && !remLoad |=>
      remLen == $past(remLen) - 1 && irq);

  p_ack_lowers_r11: assert property (@(posedge clk) disable iff (!rstN)
    intrAck && !stb.complete && !pioRd |=> !irq && !statusReg[7]);

endmodule

bind xfer_len_ctrl xfer_len_ctrl_chk #(.CNT_W(CNT_W), .REM_W(REM_W), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .tgtDone(tgtDone), .remLoad(remLoad), .pioRd(pioRd), .pioWr(pioWr),
  .intrAck(intrAck), .irq(irq), .statusReg(statusReg), .intrReg(intrReg),
  .countReg(countReg), .fifoFlags(fifoFlags), .remLen(remLen)
);

// File: tb/tb_xfer_len_ctrl.sv
module tb_xfer_len_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, cmdDma = 0, cmdPending = 0, countWr = 0, remLoad = 0;
  logic [15:0] countIn = '0;
  logic signed [23:0] remLoadVal = '0;
  logic tgtLoad = 0, tgtDone = 0, dmaAck = 0, pioRd = 0, pioWr = 0, intrAck = 0;
  logic [16:0] tgtLen = '0;
  logic [7:0] tgtStatus = '0, pioWrData = '0;
  logic dmaReq, irq;
  logic [7:0] pioData, statusReg, intrReg, senseByte;
  logic [15:0] countReg;
  logic [5:0] fifoFlags;
  logic signed [23:0] remLen;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  xfer_len_ctrl dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdDma(cmdDma),
    .cmdPending(cmdPending), .countWr(countWr), .countIn(countIn),
    .remLoad(remLoad), .remLoadVal(remLoadVal), .tgtLoad(tgtLoad),
    .tgtLen(tgtLen), .tgtDone(tgtDone), .tgtStatus(tgtStatus),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .pioRd(pioRd), .pioWr(pioWr),
    .pioWrData(pioWrData), .pioData(pioData), .intrAck(intrAck), .irq(irq),
    .statusReg(statusReg), .intrReg(intrReg), .countReg(countReg),
    .fifoFlags(fifoFlags), .remLen(remLen), .senseByte(senseByte)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int expEff(int c, int r, bit cmd);
    int ce = (c == 0) ? 65536 : c;
    int lim = cmd ? 32 : ((r < 0) ? -r : r);
    return (ce < lim) ? ce : lim;
  endfunction

  function automatic int expRem(int r, int n, bit cmd);
    if (cmd) return r;
    return (r > 0) ? r - n : r + n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack();
    intrAck = 1; step(); intrAck = 0;
  endtask

  task automatic setCount(input int c);
    countIn = c[15:0]; countWr = 1; step(); countWr = 0;
  endtask

  task automatic setRem(input int r);
    remLoadVal = r[23:0]; remLoad = 1; step(); remLoad = 0;
  endtask

  task automatic giveTgt(input int n);
    tgtLen = n[16:0]; tgtLoad = 1; step(); tgtLoad = 0;
  endtask

  task automatic startDma(input bit cmd);
    cmdStart = 1; cmdDma = 1; cmdPending = cmd; step();
    cmdStart = 0; cmdDma = 0; cmdPending = 0;
  endtask

  // accept bytes until irq or four quiet cycles
  task automatic pump(output int n);
    int quiet = 0;
    n = 0;
    dmaAck = 1;
    while (quiet < 4 && !irq) begin
      if (dmaReq) begin n++; quiet = 0; end
      else quiet++;
      step();
    end
    dmaAck = 0;
  endtask

  task automatic pioWrite(input logic [7:0] d);
    pioWrData = d; pioWr = 1; step(); pioWr = 0;
  endtask

  task automatic pioRead();
    pioRd = 1; step(); pioRd = 0;
  endtask

  initial begin
    int seedv = 32'h1d5e;
    int n;
    void'($urandom(seedv));
    repeat (3) step();
    rstN = 1;
    step();

    // R1 reset state
    chk(statusReg == 0 && intrReg == 0 && countReg == 0 && fifoFlags == 0,
        "R1 regs", {statusReg, intrReg, countReg}, 0);
    chk(remLen == 0 && senseByte == 0 && !irq && !dmaReq, "R1 misc",
        int'(remLen), 0);

    // R2/R4/R5 random effective-length runs
    for (int it = 0; it < 30; it++) begin
      int c, r, e;
      bit cmd;
      c = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 80);
      r = int'($urandom % 121);
      if ($urandom % 2 == 1) r = -r;
      cmd = ($urandom % 5 == 0);
      e = expEff(c, r, cmd);
      ack();
      setCount(c);
      setRem(r);
      giveTgt(1000);
      startDma(cmd);
      pump(n);
      chk(n == e, "R2 byte count", n, e);
      chk(int'(remLen) == expRem(r, e, cmd), "R4 remaining", int'(remLen), expRem(r, e, cmd));
      chk(irq && intrReg == 8'h10 && countReg == 0 && fifoFlags == 0 &&
          statusReg[7] && statusReg[4], "R5 completion", statusReg, 8'h90);
    end

    // R11 acknowledge, then R3 start clears bit 4
    ack();
    chk(!irq && !statusReg[7] && statusReg[4], "R11 ack", statusReg, 8'h10);
    setRem(2); giveTgt(100);
    startDma(1'b0);
    chk(!statusReg[4], "R3 start clears", statusReg, 0);
    pump(n);
    chk(n == 2 && irq, "R2 zero count is 65536 capped by length", n, 2);
    ack();
    setCount(7);
    chk(!statusReg[4], "R3 count write clears", statusReg, 0);

    // R6 pause on dry buffer, R7 deferral with zero remaining
    ack(); setCount(10); setRem(10); giveTgt(4);
    startDma(1'b0);
    pump(n);
    chk(n == 4 && !irq, "R6 pause", n, 4);
    giveTgt(6);
    pump(n);
    chk(n == 6 && !irq && remLen == 0, "R6 resume / R7 deferred", n, 6);
    giveTgt(5);
    chk(irq == 1'b1, "R7 deferred completion on load", irq, 1);

    // R7 immediate: positive remaining with empty buffer
    ack(); setCount(4); setRem(10); giveTgt(4);
    startDma(1'b0);
    pump(n);
    chk(n == 4 && irq && int'(remLen) == 6, "R7 remaining positive", int'(remLen), 6);

    // R7 immediate: partly consumed buffer
    ack(); setCount(3); setRem(10); giveTgt(8);
    startDma(1'b0);
    pump(n);
    chk(n == 3 && irq, "R7 partial buffer", n, 3);

    // R8 negative length, deferral, then end of command
    ack(); setCount(5); setRem(-3); giveTgt(3);
    startDma(1'b0);
    pump(n);
    chk(n == 3 && !irq && remLen == 0, "R8 pre host-to-device", n, 3);
    tgtStatus = 8'h02; tgtDone = 1; step(); tgtDone = 0;
    chk(statusReg == 8'h93 && senseByte == 8'h02 && irq && remLen == 0,
        "R8 end of command", statusReg, 8'h93);

    // R8 end of command mid transfer
    ack(); setCount(50); setRem(50); giveTgt(50);
    startDma(1'b0);
    dmaAck = 1; repeat (5) step();
    tgtStatus = 8'h44; tgtDone = 1; step(); tgtDone = 0;
    step();
    chk(!dmaReq && remLen == 0 && senseByte == 8'h44 && statusReg == 8'h93,
        "R8 mid transfer", int'(remLen), 0);
    dmaAck = 0;

    // R10 read with zero length
    ack(); setRem(0);
    pioRead();
    chk(!irq && remLen == 0 && pioData == 8'h00, "R10 zero length read", irq, 0);

    // R9 FIFO read and pointer reset
    pioWrite(8'hA1); pioWrite(8'hB2); pioWrite(8'hC3);
    chk(fifoFlags == 3 && int'(remLen) == 3, "R9 fill", fifoFlags, 3);
    setRem(1);
    pioRead();
    chk(pioData == 8'hA1 && remLen == 0 && irq && fifoFlags == 0, "R9 read", pioData, 8'hA1);
    ack();
    pioWrite(8'hD4);
    pioRead();
    chk(pioData == 8'hD4, "R9 pointer reset", pioData, 8'hD4);

    // R10 read with negative length
    ack(); setRem(-2);
    pioRead();
    chk(!irq && int'(remLen) == -2 && pioData == 8'hD4, "R10 negative read", int'(remLen), -2);

    // R12 non-DMA start
    ack(); setCount(5); setRem(5); giveTgt(10);
    begin
      logic [7:0] s0;
      bit sawReq = 0;
      s0 = statusReg;
      cmdStart = 1; cmdDma = 0; step(); cmdStart = 0;
      dmaAck = 1;
      for (int k = 0; k < 4; k++) begin
        if (dmaReq) sawReq = 1;
        step();
      end
      dmaAck = 0;
      chk(!sawReq && statusReg == s0 && !irq && int'(remLen) == 5,
          "R12 non-DMA start", statusReg, s0);
    end

    // R2 zero count means 65536
    ack(); setCount(0); setRem(70000); giveTgt(100000);
    startDma(1'b0);
    pump(n);
    chk(n == 65536 && int'(remLen) == 4464 && irq, "R2 full range", n, 65536);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule